// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Auto-Advancing Pointer

This block is the serial front end of a small peripheral register file. It watches the two-wire bus and tracks start and stop conditions. It answers a fixed seven-bit device address whose lowest bit comes from a strap input, and it acknowledges the bytes it receives by pulling the data line low through an open-drain enable. Both bus lines are synchronized into the system clock domain. All bus edges are detected in that domain, so the system clock must run at least eight times faster than the bus clock.

In a write transfer, the first byte after the address loads an internal pointer. Each byte after that is presented to the register file on a single-cycle write strobe, at the address the pointer holds, and the pointer then advances. A read transfer starts at the stored pointer and returns one register per byte, using the same advance rule. This means a host sets the pointer in one write and then reads in a later transfer, either after a stop or after a repeated start. The rest of the chip supplies read data, a mapped flag and a read-only flag for the address on the pointer output.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0111000 with the last of them replaced by `addr_lsb`, by driving `sda_oe` high during the ninth clock. Any other address is not acknowledged, and the block ignores the bus until the next START.
- R2: The eighth bit of the address byte selects the direction: 0 is a write from the host and 1 is a read by the host.
- R3: In a write, the first byte after the address is loaded into the pointer (`reg_addr`). If STOP follows that byte, no register write occurs and the pointer is kept for later reads.
- R4: Every later byte of a write is acknowledged and produces one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R5: After each data byte written or read, the pointer increments by one if it is below 0x7F. At 0x7F or above it holds its value.
- R6: A read returns the register at the pointer, most significant bit first, and then advances the pointer. It continues while the host acknowledges. After a host not-acknowledge, the block stops driving the data line.
- R7: START (data falls while clock is high) and STOP (data rises while clock is high) are recognised at any time. A repeated START between the pointer write and the read is supported. A START in the middle of a byte abandons that byte and restarts the address phase.
- R8: When `reg_ro` is high, a write byte is still acknowledged but no `reg_we` pulse is produced.
- R9: When `reg_hit` is low, a read byte returns 0x00, whatever `reg_rdata` holds.
- R10: After reset, `sda_oe` and `reg_we` are low and the pointer is 0x00.
- R11: The block only begins pulling the data line low while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| addr_lsb | input | 1 | Strap for the lowest address bit |
| reg_addr | output | 8 | Current pointer, the register address |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Read data for reg_addr |
| reg_hit | input | 1 | reg_addr is a mapped register |
| reg_ro | input | 1 | reg_addr is read-only |

## Verification
A corrupted pointer shows at `reg_addr` on the next system clock. It then reaches the bus in the following data byte, where a write lands at the wrong address or a read returns the wrong register. A bit counter that is off by one moves the acknowledge into a data slot, so the host sees a not-acknowledge or shifted read data within the same byte. A wrong transfer state, such as one that stays active after a not-acknowledge or misses a repeated START, shows up in the next transfer as a missing acknowledge or an unexpected write strobe.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int          PTR_W    = 8;
    localparam int          CNT_W    = 4;
    localparam logic [7:0]  PTR_CEIL = 8'h7F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } xfer_st_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p >= PTR_CEIL) ? p : p + 1'b1;
    endfunction

    function automatic logic addr_match(input logic [7:0] b,
                                        input logic [5:0] hi,
                                        input logic       lsb);
        return b[7:1] == {hi, lsb};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_rf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit
    import i2c_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (adv)  ptr <= ptr_next(ptr);
    end
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       rx_bit,
    input  logic       tx_load,
    input  logic [7:0] tx_val,
    output logic [7:0] rx_byte,
    output logic [7:0] tx_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            tx_byte <= '0;
        end else begin
            if (rx_en)   rx_byte <= {rx_byte[6:0], rx_bit};
            if (tx_load) tx_byte <= tx_val;
        end
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b011100,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             addr_lsb,
    output logic [PTR_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    input  logic [7:0]       reg_rdata,
    input  logic             reg_hit,
    input  logic             reg_ro
);
    bus_evt_t         evt;
    xfer_st_e         st;
    logic [CNT_W-1:0] bitcnt;
    logic             rw;
    logic             mack;
    logic [7:0]       rx_byte;
    logic [7:0]       tx_byte;
    logic [7:0]       tx_val;
    logic             rx_en;
    logic             tx_load;
    logic             fall8;
    logic             fall9;
    logic             ptr_load;
    logic             ptr_adv;
    logic             active;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_byte_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .rx_en   (rx_en),
        .rx_bit  (evt.sda),
        .tx_load (tx_load),
        .tx_val  (tx_val),
        .rx_byte (rx_byte),
        .tx_byte (tx_byte)
    );

    i2c_ptr_unit u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (rx_byte),
        .adv      (ptr_adv),
        .ptr      (reg_addr)
    );

    assign active = (st != ST_IDLE) && (st != ST_SKIP) && !evt.start && !evt.stop;
    assign fall8  = active && evt.scl_fall && (bitcnt == CNT_W'(8));
    assign fall9  = active && evt.scl_fall && (bitcnt == CNT_W'(9));
    assign rx_en  = active && evt.scl_rise && (bitcnt < CNT_W'(8))
                    && (st == ST_ADDR || st == ST_CMD || st == ST_WRITE);

    assign tx_val   = reg_hit ? reg_rdata : 8'h00;
    assign tx_load  = fall9 && ((st == ST_ADDR && rw) || (st == ST_READ && mack));
    assign ptr_load = fall8 && (st == ST_CMD);
    assign ptr_adv  = (fall8 && st == ST_WRITE) || tx_load;

    assign reg_we    = fall8 && (st == ST_WRITE) && !reg_ro;
    assign reg_wdata = rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            rw     <= 1'b0;
            mack   <= 1'b0;
        end else if (evt.start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (active) begin
            if (evt.scl_rise) begin
                if (st == ST_READ && bitcnt == CNT_W'(8)) mack <= ~evt.sda;
                if (bitcnt != CNT_W'(9)) bitcnt <= bitcnt + 1'b1;
            end else if (evt.scl_fall) begin
                if (bitcnt == CNT_W'(8)) begin
                    unique case (st)
                        ST_ADDR: begin
                            if (addr_match(rx_byte, ADDR_HI, addr_lsb)) begin
                                sda_oe <= 1'b1;
                                rw     <= rx_byte[0];
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                        ST_CMD, ST_WRITE: sda_oe <= 1'b1;
                        ST_READ:          sda_oe <= 1'b0;
                        default:          sda_oe <= 1'b0;
                    endcase
                end else if (bitcnt == CNT_W'(9)) begin
                    bitcnt <= '0;
                    sda_oe <= 1'b0;
                    unique case (st)
                        ST_ADDR: begin
                            st <= rw ? ST_READ : ST_CMD;
                            if (rw) sda_oe <= ~tx_val[7];
                        end
                        ST_CMD:  st <= ST_WRITE;
                        ST_READ: begin
                            if (mack) sda_oe <= ~tx_val[7];
                            else      st     <= ST_SKIP;
                        end
                        default: st <= st;
                    endcase
                end else if (st == ST_READ && bitcnt != '0) begin
                    sda_oe <= ~tx_byte[3'(4'd7 - bitcnt)];
                end
            end
        end
    end

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       reg_we,
    input logic       reg_ro,
    input logic [7:0] reg_addr
);
    // R4
    we_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R8
    ro_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !reg_ro);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr < 8'h7F) |=> reg_addr == $past(reg_addr) + 8'd1);

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr >= 8'h7F) |=> reg_addr == $past(reg_addr));

    // R11
    drive_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_regfile_slave i2c_rf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_ro   (reg_ro),
    .reg_addr (reg_addr)
);

// File: tb/sim_i2c_regfile_slave.sv
`timescale 1ns/1ps
module sim_i2c_regfile_slave;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_lsb = 1'b0;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_hit, reg_ro;
    logic       sda_line;
    logic [7:0] mem [0:127];
    int         we_cnt;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_ro    = (reg_addr >= 8'h10) && (reg_addr <= 8'h13);
    assign reg_hit   = (reg_addr <= 8'h13) || (reg_addr == 8'h7E) || (reg_addr == 8'h7F);
    assign reg_rdata = reg_ro ? (8'hA0 | {6'b0, reg_addr[1:0]}) : mem[reg_addr[6:0]];

    i2c_regfile_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_lsb(addr_lsb), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_hit(reg_hit), .reg_ro(reg_ro)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
            mem[8'h40] <= 8'hEE;
            we_cnt <= 0;
        end else if (reg_we) begin
            mem[reg_addr[6:0]] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(posedge clk); #1; endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
        end
        wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    // write transfer: address, command, then n data bytes
    task automatic wr_xfer(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2, input string tag);
        logic a;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte({6'b011100, addr_lsb, 1'b0}, a); chk(a, {tag, " addr ack"}, a, 1);
        send_byte(cmd, a);                         chk(a, {tag, " cmd ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a);                    chk(a, {tag, " data ack"}, a, 1);
        end
        bus_stop();
    endtask

    task automatic rd_one(input logic [7:0] exp, input string tag);
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte({6'b011100, addr_lsb, 1'b1}, a); chk(a, {tag, " rd addr ack"}, a, 1);
        recv_byte(1'b0, v);                        chk(v == exp, tag, v, exp);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
        chk(reg_we == 1'b0, "R10 reg_we", reg_we, 0);
        chk(reg_addr == 8'h00, "R10 pointer", reg_addr, 0);
    endtask

    task automatic t_write_single();
        wr_xfer(8'h03, 1, 8'h5A, 8'h00, 8'h00, "R4");
        chk(mem[3] == 8'h5A, "R4 single write", mem[3], 8'h5A);
        chk(reg_addr == 8'h04, "R5 pointer after write", reg_addr, 8'h04);
    endtask

    task automatic t_write_multi();
        wr_xfer(8'h05, 3, 8'h11, 8'h22, 8'h33, "R5");
        wr_xfer(8'h08, 1, 8'h44, 8'h00, 8'h00, "R5");
        chk(mem[5] == 8'h11 && mem[6] == 8'h22 && mem[7] == 8'h33, "R5 autoinc write",
            {mem[5], mem[6], mem[7]}, 24'h112233);
    endtask

    task automatic t_cmd_only();
        int c0;
        c0 = we_cnt;
        wr_xfer(8'h06, 0, 8'h00, 8'h00, 8'h00, "R3");
        chk(we_cnt == c0, "R3 no write on command only", we_cnt, c0);
        rd_one(8'h22, "R3 read via stored pointer");
    endtask

    task automatic t_rs_read();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'h70, a); chk(a, "R7 addr ack", a, 1);
        send_byte(8'h05, a); chk(a, "R7 cmd ack", a, 1);
        bus_start();
        send_byte(8'h71, a); chk(a, "R2 read addr ack", a, 1);
        recv_byte(1'b1, v);  chk(v == 8'h11, "R6 read byte0", v, 8'h11);
        recv_byte(1'b1, v);  chk(v == 8'h22, "R6 read byte1", v, 8'h22);
        recv_byte(1'b0, v);  chk(v == 8'h33, "R6 read byte2", v, 8'h33);
        chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        bus_stop();
        rd_one(8'h44, "R6 read continues from pointer");
    endtask

    task automatic t_saturate();
        logic a;
        logic [7:0] v;
        wr_xfer(8'h7E, 3, 8'hA1, 8'hB2, 8'hC3, "R5");
        chk(mem[8'h7E] == 8'hA1, "R5 write at 7E", mem[8'h7E], 8'hA1);
        chk(mem[8'h7F] == 8'hC3, "R5 saturated write at 7F", mem[8'h7F], 8'hC3);
        chk(reg_addr == 8'h7F, "R5 pointer holds", reg_addr, 8'h7F);
        bus_start();
        send_byte(8'h71, a);
        recv_byte(1'b1, v); chk(v == 8'hC3, "R5 read 7F first", v, 8'hC3);
        recv_byte(1'b0, v); chk(v == 8'hC3, "R5 read 7F again", v, 8'hC3);
        bus_stop();
    endtask

    task automatic t_read_only();
        int c0;
        c0 = we_cnt;
        wr_xfer(8'h11, 1, 8'h99, 8'h00, 8'h00, "R8");
        chk(we_cnt == c0, "R8 no strobe on read-only", we_cnt, c0);
        wr_xfer(8'h11, 0, 8'h00, 8'h00, 8'h00, "R8");
        rd_one(8'hA1, "R8 read-only value kept");
    endtask

    task automatic t_unmapped();
        wr_xfer(8'h40, 0, 8'h00, 8'h00, 8'h00, "R9");
        rd_one(8'h00, "R9 unmapped reads zero");
    endtask

    task automatic t_mismatch();
        logic a;
        int c0;
        c0 = we_cnt;
        bus_start();
        send_byte(8'h72, a); chk(!a, "R1 foreign address nack", a, 0);
        send_byte(8'h03, a); chk(!a, "R1 ignored after nack", a, 0);
        send_byte(8'hFF, a);
        bus_stop();
        chk(we_cnt == c0 && mem[3] == 8'h5A, "R1 no write when not addressed", we_cnt, c0);
    endtask

    task automatic t_strap();
        logic a;
        addr_lsb = 1'b1;
        wr_xfer(8'h02, 1, 8'h77, 8'h00, 8'h00, "R1 strap");
        chk(mem[2] == 8'h77, "R1 strap write", mem[2], 8'h77);
        bus_start();
        send_byte(8'h70, a); chk(!a, "R1 strap other address nack", a, 0);
        bus_stop();
        addr_lsb = 1'b0;
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'h70, a); chk(a, "R7 ack after mid-byte restart", a, 1);
        send_byte(8'h00, a);
        send_byte(8'h5C, a);
        bus_stop();
        chk(mem[0] == 8'h5C, "R7 write after abort", mem[0], 8'h5C);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        wq();
        t_reset();
        t_write_single();
        t_write_multi();
        t_cmd_only();
        t_rs_read();
        t_saturate();
        t_read_only();
        t_unmapped();
        t_mismatch();
        t_strap();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule